// File: doc/BRIEF.md
# Big-Endian Sub-Word Access Steering Unit

This block sits between a 32-bit processor core and a data memory organised as 32-bit words. It turns byte-addressed accesses of byte, halfword or word size into what a word-wide memory needs. On the store side it takes a byte address, a size code and a register value. It returns the word address, four byte-lane write strobes and a write word with the source bits copied onto the lanes being written.

On the load side it takes the word returned by memory, the low two bits of the byte address, the size code and a signed/unsigned selector. It picks out the addressed byte or halfword and widens it to a full 32-bit register value. Lane order is big-endian: byte offset 0 is the most significant byte of the word.

Both sides flag an access that does not fall on a multiple of its own size. A flagged store writes no lane. The unit is purely combinational, so results are valid in the same cycle as the request.

Top module: `lsa_unit`

## Requirements
- R1: `mem_waddr_o` equals the store byte address with its two least significant bits removed.
- R2: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. Strobe bit `3-k` of `mem_be_o` is the lane for byte offset k. A byte at offset k raises only bit `3-k`. A halfword at offset 0 gives 4'b1100 and one at offset 2 gives 4'b0011. A word gives 4'b1111.
- R3: For a byte store, `mem_wdata_o` carries the low 8 source bits on all four lanes. For a halfword store it carries the low 16 source bits in both halves. For a word store it carries the source value unchanged.
- R4: A store raises `st_misalign_o` and drives `mem_be_o` to 4'b0000 when any of these holds: it is a halfword at an odd offset, it is a word at a nonzero offset, or it uses the reserved size 11.
- R5: `ld_misalign_o` follows the rule of R4, applied to `ld_ofs_i` and `ld_size_i`.
- R6: A byte load at offset k takes memory bits `[31-8k : 24-8k]`, so offset 0 takes the most significant byte.
- R7: A halfword load at offset 0 takes memory bits 31:16, and one at offset 2 takes bits 15:0.
- R8: With `ld_signed_i`=1, byte and halfword loads copy the top bit of the loaded value into every higher result bit. With `ld_signed_i`=0, those higher bits are zero. All 32 result bits are always driven.
- R9: An aligned word load returns the memory word unchanged, whatever the value of `ld_signed_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_addr_i | input | ADDR_W | Store byte address |
| st_size_i | input | 2 | Store size code |
| st_data_i | input | 32 | Store source register value |
| mem_waddr_o | output | ADDR_W-2 | Word address to memory |
| mem_be_o | output | 4 | Byte-lane write strobes, bit 3 is offset 0 |
| mem_wdata_o | output | 32 | Lane-steered write word |
| st_misalign_o | output | 1 | Store alignment fault |
| ld_rdata_i | input | 32 | Word read from memory |
| ld_ofs_i | input | 2 | Load byte offset within the word |
| ld_size_i | input | 2 | Load size code |
| ld_signed_i | input | 1 | 1 = sign-extend, 0 = zero-extend |
| ld_value_o | output | 32 | Widened register value |
| ld_misalign_o | output | 1 | Load alignment fault |

## Verification
On every evaluation, the assertions check that a faulted store writes no lane. They check that an aligned store raises exactly as many strobes as its size has bytes. They check that every lane written by a byte store carries the source byte, that the word address and offset put back together give the byte address, and that narrow loads fill their upper bits with zeros or with copies of the top loaded bit. Only the bench scenarios can show which lane an offset selects and which half of the word a halfword load takes. The same holds for the exact data on the replicated lanes, and for word loads coming through untouched under both signedness settings.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int OFS_W  = $clog2(LANES);
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // An access is faulty when the offset is not a multiple of its size.
  function automatic logic is_misaligned(acc_size_e sz, logic [OFS_W-1:0] ofs);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return ofs[0];
      SZ_WORD: return (ofs != '0);
      default: return 1'b1;
    endcase
  endfunction

  // Big-endian: offset k owns strobe bit LANES-1-k.
  function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFS_W-1:0] ofs);
    logic [LANES-1:0] m;
    case (sz)
      SZ_BYTE: m = {{(LANES-1){1'b0}}, 1'b1} << (LANES - 1 - int'(ofs));
      SZ_HALF: m = {{(LANES-2){1'b0}}, 2'b11} << (LANES - 2 - int'(ofs));
      SZ_WORD: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Extension of a narrow field to a full word.
  function automatic logic [WORD_W-1:0] widen8(logic [7:0] v, logic sgn);
    return {{(WORD_W-8){sgn & v[7]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] widen16(logic [HALF_W-1:0] v, logic sgn);
    return {{(WORD_W-HALF_W){sgn & v[HALF_W-1]}}, v};
  endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
  import lsa_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             fault_o
);
  always_comb fault_o = is_misaligned(acc_size_e'(size_i), ofs_i);
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              fault_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o
);
  acc_size_e sz;
  always_comb sz = acc_size_e'(size_i);

  always_comb be_o = fault_i ? '0 : lane_mask(sz, ofs_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      case (sz)
        SZ_BYTE: wdata_o[8*l +: 8] = data_i[7:0];
        SZ_HALF: wdata_o[8*l +: 8] = data_i[8*(l % 2) +: 8];
        default: wdata_o[8*l +: 8] = data_i[8*l +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  output logic [WORD_W-1:0] value_o
);
  logic [7:0]        byte_sel;
  logic [HALF_W-1:0] half_sel;

  always_comb begin
    byte_sel = rdata_i[8*(LANES-1-int'(ofs_i)) +: 8];
    half_sel = rdata_i[HALF_W*(1-int'(ofs_i[OFS_W-1])) +: HALF_W];
    case (acc_size_e'(size_i))
      SZ_BYTE: value_o = widen8(byte_sel, signed_i);
      SZ_HALF: value_o = widen16(half_sel, signed_i);
      default: value_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [1:0]              st_size_i,
  input  logic [31:0]             st_data_i,
  output logic [ADDR_W-OFS_W-1:0] mem_waddr_o,
  output logic [3:0]              mem_be_o,
  output logic [31:0]             mem_wdata_o,
  output logic                    st_misalign_o,
  input  logic [31:0]             ld_rdata_i,
  input  logic [1:0]              ld_ofs_i,
  input  logic [1:0]              ld_size_i,
  input  logic                    ld_signed_i,
  output logic [31:0]             ld_value_o,
  output logic                    ld_misalign_o
);
  // Named internal events for the checker.
  logic [OFS_W-1:0] st_ofs;
  logic             st_fault;
  logic             ld_fault;

  always_comb st_ofs      = st_addr_i[OFS_W-1:0];
  always_comb mem_waddr_o = st_addr_i[ADDR_W-1:OFS_W];

  lsa_align_check u_st_chk (.size_i(st_size_i), .ofs_i(st_ofs),   .fault_o(st_fault));
  lsa_align_check u_ld_chk (.size_i(ld_size_i), .ofs_i(ld_ofs_i),  .fault_o(ld_fault));

  lsa_store_steer u_steer (
    .size_i (st_size_i),
    .ofs_i  (st_ofs),
    .data_i (st_data_i),
    .fault_i(st_fault),
    .be_o   (mem_be_o),
    .wdata_o(mem_wdata_o)
  );

  lsa_load_extract u_extract (
    .rdata_i (ld_rdata_i),
    .ofs_i   (ld_ofs_i),
    .size_i  (ld_size_i),
    .signed_i(ld_signed_i),
    .value_o (ld_value_o)
  );

  always_comb st_misalign_o = st_fault;
  always_comb ld_misalign_o = ld_fault;
endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic [ADDR_W-1:0] st_addr_i,
  input logic [1:0]        st_size_i,
  input logic [31:0]       st_data_i,
  input logic [ADDR_W-3:0] mem_waddr_o,
  input logic [3:0]        mem_be_o,
  input logic [31:0]       mem_wdata_o,
  input logic              st_fault,
  input logic [1:0]        ld_size_i,
  input logic              ld_signed_i,
  input logic              ld_misalign_o,
  input logic [31:0]       ld_value_o
);
  always_comb begin
    // R1
    waddr_join_chk: assert ({mem_waddr_o, st_addr_i[1:0]} == st_addr_i)
      else $error("word address does not rebuild byte address");
    // R4
    fault_quiet_chk: assert (!st_fault || mem_be_o == 4'b0000)
      else $error("faulted store still strobes a lane");
    // R2
    strobe_count_chk: assert (st_fault ||
        $countones(mem_be_o) == ((st_size_i == 2'b00) ? 1 : (st_size_i == 2'b01) ? 2 : 4))
      else $error("strobe count does not match size");
    // R3
    byte_lane_chk: assert (st_size_i != 2'b00 || st_fault ||
        (mem_be_o[3] ? mem_wdata_o[31:24] == st_data_i[7:0] : 1'b1) &&
        (mem_be_o[2] ? mem_wdata_o[23:16] == st_data_i[7:0] : 1'b1) &&
        (mem_be_o[1] ? mem_wdata_o[15:8]  == st_data_i[7:0] : 1'b1) &&
        (mem_be_o[0] ? mem_wdata_o[7:0]   == st_data_i[7:0] : 1'b1))
      else $error("written byte lane does not carry source byte");
    // R8
    byte_ext_chk: assert (ld_size_i != 2'b00 ||
        ld_value_o[31:8] == {24{ld_signed_i & ld_value_o[7]}})
      else $error("byte load upper bits wrong");
    // R8
    half_ext_chk: assert (ld_size_i != 2'b01 || ld_misalign_o ||
        ld_value_o[31:16] == {16{ld_signed_i & ld_value_o[15]}})
      else $error("halfword load upper bits wrong");
  end
endmodule

bind lsa_unit lsa_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .st_addr_i    (st_addr_i),
  .st_size_i    (st_size_i),
  .st_data_i    (st_data_i),
  .mem_waddr_o  (mem_waddr_o),
  .mem_be_o     (mem_be_o),
  .mem_wdata_o  (mem_wdata_o),
  .st_fault     (st_fault),
  .ld_size_i    (ld_size_i),
  .ld_signed_i  (ld_signed_i),
  .ld_misalign_o(ld_misalign_o),
  .ld_value_o   (ld_value_o)
);

// File: tb/lsa_unit_tb_top.sv
module lsa_unit_tb_top;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [ADDR_W-1:0] st_addr_i;
  logic [1:0]        st_size_i;
  logic [31:0]       st_data_i;
  logic [ADDR_W-3:0] mem_waddr_o;
  logic [3:0]        mem_be_o;
  logic [31:0]       mem_wdata_o;
  logic              st_misalign_o;
  logic [31:0]       ld_rdata_i;
  logic [1:0]        ld_ofs_i;
  logic [1:0]        ld_size_i;
  logic              ld_signed_i;
  logic [31:0]       ld_value_o;
  logic              ld_misalign_o;

  lsa_unit #(.ADDR_W(ADDR_W)) dut_i (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Stimulus table: {offset[1:0], size[1:0], strobes[3:0], fault}
  localparam logic [8:0] STORE_TBL [12] = '{
    {2'd0, 2'b00, 4'b1000, 1'b0}, {2'd1, 2'b00, 4'b0100, 1'b0},
    {2'd2, 2'b00, 4'b0010, 1'b0}, {2'd3, 2'b00, 4'b0001, 1'b0},
    {2'd0, 2'b01, 4'b1100, 1'b0}, {2'd1, 2'b01, 4'b0000, 1'b1},
    {2'd2, 2'b01, 4'b0011, 1'b0}, {2'd3, 2'b01, 4'b0000, 1'b1},
    {2'd0, 2'b10, 4'b1111, 1'b0}, {2'd1, 2'b10, 4'b0000, 1'b1},
    {2'd2, 2'b10, 4'b0000, 1'b1}, {2'd3, 2'b11, 4'b0000, 1'b1}
  };

  function automatic logic [31:0] want_wdata(logic [1:0] sz, logic [31:0] d);
    if (sz == 2'b00) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 2'b01) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] want_load(logic [31:0] rd, logic [1:0] ofs,
                                            logic [1:0] sz, logic sgn);
    logic [31:0] v;
    if (sz == 2'b00) begin
      v = (rd >> (24 - 8 * ofs)) & 32'hFF;
      if (sgn && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 2'b01) begin
      v = (ofs == 2'd0) ? (rd >> 16) : (rd & 32'hFFFF);
      if (sgn && v[15]) v = v | 32'hFFFF_0000;
    end else v = rd;
    return v;
  endfunction

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
          $finish;
        end
      end
    join_none

    st_addr_i = '0; st_size_i = 2'b10; st_data_i = '0;
    ld_rdata_i = '0; ld_ofs_i = '0; ld_size_i = 2'b10; ld_signed_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state after reset: aligned word at address zero
    check("R2 idle strobes", 32'(mem_be_o), 32'hF);
    check("R4 idle fault", 32'(st_misalign_o), 32'd0);
    check("R5 idle load fault", 32'(ld_misalign_o), 32'd0);

    // Table walk over store offsets and sizes
    foreach (STORE_TBL[i]) begin
      @(posedge clk);
      st_addr_i = 32'h1234_5670 | 32'(STORE_TBL[i][8:7]);
      st_size_i = STORE_TBL[i][6:5];
      st_data_i = 32'hA1B2_C3D4 ^ (32'(i) << 4);
      @(negedge clk);
      check("R1 word address", 32'(mem_waddr_o), 32'h048D_159C);
      check("R2 strobes", 32'(mem_be_o), 32'(STORE_TBL[i][4:1]));
      check("R4 store fault", 32'(st_misalign_o), 32'(STORE_TBL[i][0]));
      if (!STORE_TBL[i][0])
        check("R3 write data", mem_wdata_o, want_wdata(st_size_i, st_data_i));
    end

    // High address bits pass to word address
    @(posedge clk);
    st_addr_i = 32'hFFFF_FFFE; st_size_i = 2'b01; st_data_i = 32'h0000_BEEF;
    @(negedge clk);
    check("R1 top address", 32'(mem_waddr_o), 32'h3FFF_FFFF);
    check("R2 half low strobes", 32'(mem_be_o), 32'h3);
    check("R3 half replicate", mem_wdata_o, 32'hBEEF_BEEF);

    // Load sweep: all aligned narrow combinations, two memory patterns
    for (int p = 0; p < 2; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int s = 0; s < 2; s++) begin
          for (int g = 0; g < 2; g++) begin
            if (s == 1 && (o % 2) == 1) continue;
            @(posedge clk);
            ld_rdata_i  = (p == 0) ? 32'h80FF_7F01 : 32'h7E81_017F;
            ld_ofs_i    = 2'(o);
            ld_size_i   = 2'(s);
            ld_signed_i = g[0];
            @(negedge clk);
            check(s == 0 ? "R6 R8 byte load" : "R7 R8 half load", ld_value_o,
                  want_load(ld_rdata_i, ld_ofs_i, ld_size_i, ld_signed_i));
          end
        end
      end
    end

    // Word load untouched by signedness
    for (int g = 0; g < 2; g++) begin
      @(posedge clk);
      ld_rdata_i = 32'hF00D_8001; ld_ofs_i = 2'd0; ld_size_i = 2'b10; ld_signed_i = g[0];
      @(negedge clk);
      check("R9 word load", ld_value_o, 32'hF00D_8001);
    end

    // Load fault flag over every offset and size
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 4; s++) begin
        @(posedge clk);
        ld_ofs_i = 2'(o); ld_size_i = 2'(s);
        @(negedge clk);
        check("R5 load fault", 32'(ld_misalign_o),
              32'((s == 3) || (s == 1 && o % 2 == 1) || (s == 2 && o != 0)));
      end
    end

    // Reserved size on an otherwise aligned store
    @(posedge clk);
    st_addr_i = 32'h0000_0100; st_size_i = 2'b11; st_data_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R4 reserved size fault", 32'(st_misalign_o), 32'd1);
    check("R4 reserved size strobes", 32'(mem_be_o), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule